// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A requester hands it a 20-bit virtual page number together with the current value of the per-process page table base register. The walker splits the page number into an upper and a lower 10-bit index. It reads one entry from the root table, which gives the base of a partial second-level table. It then reads one entry from that table, which gives the physical frame number and the permission bits. The outcome is either the frame and its flags, ready to refill a translation cache, or a fault that reports which level held the unmapped entry.

Only the parts of the table in use need to exist. A root entry with its valid bit clear ends the walk at once, so no second-level table is touched for that region. The root is supplied with every request, which means a context switch only needs a new base value. The memory side is a single-outstanding read port. The walker holds a request and its address until the memory acknowledges it, and it accepts the data in the same cycle as the acknowledge.

Top module: `pt_walker`

## Requirements
- R1: After synchronous reset, walk_ready is 1 and mem_req and res_valid are 0.
- R2: The first read address is walk_root plus four times the upper index, where the upper index is walk_vpn[19:10].
- R3: When the first entry is valid, the second read address is the first entry with bits 11:0 cleared, plus four times the lower index walk_vpn[9:0].
- R4: A successful walk raises res_valid for exactly one cycle, with res_fault 0, res_frame equal to bits 31:12 of the second entry, and res_flags equal to bits 5:1 of that entry (bit 1 read-only, bit 2 no-execute, bit 3 kernel-only, bit 4 accessed, bit 5 dirty).
- R5: A first entry with bit 0 (valid) clear ends the walk with res_fault 1 and res_level 0, after exactly one memory read.
- R6: A second entry with bit 0 clear ends the walk with res_fault 1 and res_level 1, after exactly two memory reads.
- R7: Once raised, mem_req stays high with mem_addr unchanged until a cycle in which mem_ack is 1, for any number of wait cycles.
- R8: A new request is taken only while walk_ready is 1; walk_valid has no effect from acceptance until res_valid has pulsed, and no further read is issued after the result.
- R9: mem_req rises in the cycle after acceptance, the second read is presented in the cycle after the first acknowledge, and res_valid rises in the cycle after the final acknowledge.
- R10: Each request uses its own walk_root, so the same page number under two different roots resolves through two different tables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | Walk request strobe |
| walk_vpn | input | 20 | Virtual page number to translate |
| walk_root | input | 32 | Page table base register value (byte address of root table) |
| walk_ready | output | 1 | Walker idle and able to accept a request |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the table entry being read |
| mem_ack | input | 1 | Memory read acknowledge, data valid this cycle |
| mem_rdata | input | 32 | Table entry returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended on an unmapped entry |
| res_level | output | 1 | Level of the faulting entry (0 root, 1 second level) |
| res_frame | output | 20 | Physical frame number on success |
| res_flags | output | 5 | Permission and status bits on success |

## Verification
With a memory that acknowledges d cycles after it first sees a request, res_valid is due 2d+3 falling edges after the accepting clock edge for a two-read walk, and d+2 for a walk that faults at the root. Each walk counts falling edges from acceptance, compares the count against that figure, and reads the result fields only in that cycle. In the following cycle it checks that the strobe has dropped. The memory model records every address at the falling edge after it is presented and checks it against the expected value on each wait cycle. Read counts are checked two cycles after the result, which shows that a held walk_valid started nothing.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1,
    WS_L2,
    WS_DONE,
    WS_FAULT
  } walk_state_t;

  // bit position of the present flag inside a table entry
  localparam int PTE_VALID_BIT = 0;
  // lowest bit of the permission/status field
  localparam int PTE_FLAG_LSB  = 1;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  tbl_idx,
  output logic [ADDR_W-1:0] entry_addr
);

  localparam int SHIFT = $clog2(ENTRY_BYTES);

  assign entry_addr = tbl_base + (ADDR_W'(tbl_idx) << SHIFT);

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walk_pkg::*;
#(
  parameter int PTE_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int FLAG_W     = 5
) (
  input  logic [PTE_W-1:0]            entry,
  output logic                        present,
  output logic [ADDR_W-1:0]           next_base,
  output logic [PTE_W-PAGE_SHIFT-1:0] frame,
  output logic [FLAG_W-1:0]           flags
);

  logic rsvd_unused;

  assign present     = entry[PTE_VALID_BIT];
  assign frame       = entry[PTE_W-1:PAGE_SHIFT];
  assign next_base   = ADDR_W'({entry[PTE_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}});
  assign flags       = entry[PTE_FLAG_LSB +: FLAG_W];
  assign rsvd_unused = ^entry[PAGE_SHIFT-1:PTE_FLAG_LSB+FLAG_W];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int HI_W       = 10,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int FLAG_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        walk_valid,
  input  logic [VPN_W-1:0]            walk_vpn,
  input  logic [ADDR_W-1:0]           walk_root,
  output logic                        walk_ready,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_ack,
  input  logic [PTE_W-1:0]            mem_rdata,
  output logic                        res_valid,
  output logic                        res_fault,
  output logic                        res_level,
  output logic [PTE_W-PAGE_SHIFT-1:0] res_frame,
  output logic [FLAG_W-1:0]           res_flags
);

  localparam int LO_W        = VPN_W - HI_W;
  localparam int FRAME_W     = PTE_W - PAGE_SHIFT;
  localparam int ENTRY_BYTES = PTE_W / 8;

  walk_state_t         state;
  logic [LO_W-1:0]     lo_idx_q;
  logic [ADDR_W-1:0]   l1_addr;
  logic [ADDR_W-1:0]   l2_addr;
  logic                ent_present;
  logic [ADDR_W-1:0]   ent_base;
  logic [FRAME_W-1:0]  ent_frame;
  logic [FLAG_W-1:0]   ent_flags;

  // root table entry address, formed straight from the request
  pt_entry_addr #(
    .ADDR_W(ADDR_W), .IDX_W(HI_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_l1_addr (
    .tbl_base  (walk_root),
    .tbl_idx   (walk_vpn[VPN_W-1:LO_W]),
    .entry_addr(l1_addr)
  );

  // second-level entry address, from the returned root entry
  pt_entry_addr #(
    .ADDR_W(ADDR_W), .IDX_W(LO_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_l2_addr (
    .tbl_base  (ent_base),
    .tbl_idx   (lo_idx_q),
    .entry_addr(l2_addr)
  );

  pt_entry_decode #(
    .PTE_W(PTE_W), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .FLAG_W(FLAG_W)
  ) u_decode (
    .entry    (mem_rdata),
    .present  (ent_present),
    .next_base(ent_base),
    .frame    (ent_frame),
    .flags    (ent_flags)
  );

  assign walk_ready = (state == WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WS_IDLE;
      lo_idx_q  <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_level <= 1'b0;
      res_frame <= '0;
      res_flags <= '0;
    end else begin
      case (state)
        WS_IDLE: begin
          res_valid <= 1'b0;
          if (walk_valid) begin
            lo_idx_q <= walk_vpn[LO_W-1:0];
            mem_addr <= l1_addr;
            mem_req  <= 1'b1;
            state    <= WS_L1;
          end
        end
        WS_L1: begin
          if (mem_ack) begin
            if (!ent_present) begin
              mem_req   <= 1'b0;
              res_valid <= 1'b1;
              res_fault <= 1'b1;
              res_level <= 1'b0;
              res_frame <= '0;
              res_flags <= '0;
              state     <= WS_FAULT;
            end else begin
              mem_addr <= l2_addr;
              state    <= WS_L2;
            end
          end
        end
        WS_L2: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            res_valid <= 1'b1;
            res_level <= 1'b1;
            if (!ent_present) begin
              res_fault <= 1'b1;
              res_frame <= '0;
              res_flags <= '0;
              state     <= WS_FAULT;
            end else begin
              res_fault <= 1'b0;
              res_frame <= ent_frame;
              res_flags <= ent_flags;
              state     <= WS_DONE;
            end
          end
        end
        WS_DONE, WS_FAULT: begin
          res_valid <= 1'b0;
          state     <= WS_IDLE;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5
  l1_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (state == WS_L1 && mem_ack && !mem_rdata[PTE_VALID_BIT])
      |=> (res_valid && res_fault && !res_level && !mem_req));

  // R6
  l2_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (state == WS_L2 && mem_ack && !mem_rdata[PTE_VALID_BIT])
      |=> (res_valid && res_fault && res_level && !mem_req));

  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9
  issue_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_valid && walk_ready) |=> (mem_req && !walk_ready));

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid) |-> (!walk_ready && !mem_req));

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  localparam logic [31:0] ROOT_A = 32'h0010_0000;
  localparam logic [31:0] ROOT_B = 32'h0030_0000;
  localparam logic [31:0] L2A    = 32'h0200_0000;
  localparam logic [31:0] L2B    = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        walk_valid = 1'b0;
  logic [19:0] walk_vpn = '0;
  logic [31:0] walk_root = '0;
  logic        walk_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic        res_fault;
  logic        res_level;
  logic [19:0] res_frame;
  logic [4:0]  res_flags;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [0:3];

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .walk_valid(walk_valid), .walk_vpn(walk_vpn),
    .walk_root(walk_root), .walk_ready(walk_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_fault(res_fault), .res_level(res_level),
    .res_frame(res_frame), .res_flags(res_flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // table contents held by the memory model, computed from the address
  function automatic logic [31:0] tbl(input logic [31:0] a);
    logic [31:0] i, p0, p1, fr, fl;
    if (a >= ROOT_A && a < ROOT_A + 32'h1000) begin
      i  = (a - ROOT_A) >> 2;
      fr = 32'h02000 + i;
      return {fr[19:0], 11'd0, (i % 5) != 4};
    end else if (a >= ROOT_B && a < ROOT_B + 32'h1000) begin
      i  = (a - ROOT_B) >> 2;
      fr = 32'h04000 + i;
      return {fr[19:0], 11'd0, (i % 5) != 3};
    end else if (a >= L2A && a < L2A + 32'h0040_0000) begin
      p0 = (a - L2A) >> 12;
      p1 = (a >> 2) & 32'h3FF;
      fr = p0 * 37 + p1 * 11 + 1;
      fl = (p0 + p1) & 32'h1F;
      return {fr[19:0], 6'd0, fl[4:0], (p1 % 7) != 6};
    end else if (a >= L2B && a < L2B + 32'h0040_0000) begin
      p0 = (a - L2B) >> 12;
      p1 = (a >> 2) & 32'h3FF;
      fr = p0 * 53 + p1 * 3 + 2;
      fl = (p0 ^ p1) & 32'h1F;
      return {fr[19:0], 6'd0, fl[4:0], (p1 % 7) != 5};
    end
    return 32'hFFFF_F000;
  endfunction

  // memory responder: acknowledges lat falling edges after seeing a request
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        logic [31:0] seen;
        seen = mem_addr;
        if (rd_cnt < 4) rd_addr[rd_cnt] = seen;
        rd_cnt++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          // R7: request and address held while waiting
          chk(mem_req && mem_addr == seen, "R7", mem_addr, seen);
        end
        mem_rdata = tbl(seen);
        mem_ack   = 1'b1;
      end
    end
  end

  task automatic walk(input logic [31:0] root, input logic [19:0] vpn,
                      input int d, input bit junk);
    logic [31:0] a1, a2, e1, e2, p0, p1;
    int exp_reads, exp_cyc, cyc;
    string fr_req;
    p0 = {22'd0, vpn[19:10]};
    p1 = {22'd0, vpn[9:0]};
    a1 = root + p0 * 4;
    e1 = tbl(a1);
    a2 = {e1[31:12], 12'd0} + p1 * 4;
    e2 = tbl(a2);
    exp_reads = e1[0] ? 2 : 1;
    exp_cyc   = e1[0] ? 2 * d + 3 : d + 2;
    fr_req    = (root == ROOT_B) ? "R10" : "R4";
    lat    = d;
    rd_cnt = 0;
    @(negedge clk);
    chk(walk_ready == 1'b1, "R8", {31'd0, walk_ready}, 32'd1);
    walk_valid = 1'b1;
    walk_vpn   = vpn;
    walk_root  = root;
    @(negedge clk);
    if (junk) begin
      walk_vpn  = ~vpn;
      walk_root = ROOT_A ^ ROOT_B ^ root;
    end else begin
      walk_valid = 1'b0;
    end
    cyc = 1;
    while (!res_valid && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    walk_valid = 1'b0;
    chk(cyc == exp_cyc, "R9", cyc, exp_cyc);
    chk(rd_addr[0] == a1, "R2", rd_addr[0], a1);
    if (e1[0]) begin
      chk(rd_addr[1] == a2, "R3", rd_addr[1], a2);
      if (e2[0]) begin
        chk(res_fault == 1'b0, "R4", {31'd0, res_fault}, 32'd0);
        chk(res_frame == e2[31:12], fr_req, {12'd0, res_frame}, {12'd0, e2[31:12]});
        chk(res_flags == e2[5:1], "R4", {27'd0, res_flags}, {27'd0, e2[5:1]});
      end else begin
        chk(res_fault && res_level, "R6", {30'd0, res_fault, res_level}, 32'd3);
      end
    end else begin
      chk(res_fault && !res_level, "R5", {30'd0, res_fault, res_level}, 32'd2);
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R4", {31'd0, res_valid}, 32'd0);
    repeat (2) @(negedge clk);
    chk(rd_cnt == exp_reads, e1[0] ? (e2[0] ? "R8" : "R6") : "R5", rd_cnt, exp_reads);
    chk(mem_req == 1'b0 && walk_ready == 1'b1, "R8",
        {30'd0, mem_req, walk_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(walk_ready == 1'b1, "R1", {31'd0, walk_ready}, 32'd1);
    chk(mem_req == 1'b0, "R1", {31'd0, mem_req}, 32'd0);
    chk(res_valid == 1'b0, "R1", {31'd0, res_valid}, 32'd0);

    // sweep of both roots over corner and interior indices
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic [9:0] hi, lo;
          hi = (i == 0) ? 10'd0 : (i == 1) ? 10'd1 : (i == 2) ? 10'd3 :
               (i == 3) ? 10'd4 : (i == 4) ? 10'd512 : 10'd1023;
          lo = (j == 0) ? 10'd0 : (j == 1) ? 10'd5 : (j == 2) ? 10'd6 :
               (j == 3) ? 10'd13 : (j == 4) ? 10'd600 : 10'd1023;
          walk(r == 0 ? ROOT_A : ROOT_B, {hi, lo}, (i + j) % 4, (j % 2) == 1);
        end
      end
    end
    // every flag combination, with a longer memory wait
    for (int k = 0; k < 64; k++)
      walk(ROOT_A, {10'd7, 10'(k)}, k % 6, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule